// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is the synchronous control core of a pipelined burst SRAM that never inserts idle cycles when the traffic switches between reads and writes. Every control input is captured on the rising clock edge. A command issued at one enabled edge has its data phase two enabled edges later. For a read, the data phase is when the registered word appears on the read bus with the output enable high. For a write, it is when the word on the write bus is captured into the array. Any mix of reads and writes therefore runs at one transfer per clock.

The core holds the write address in a two-stage command pipeline, so the write data lands at the correct location. A read that targets a word whose write data is still in flight receives that data, merged lane by lane, in place of the stale array contents. Each command either loads a new address or advances a two-bit burst counter in linear or interleaved order. A low clock enable freezes the whole core. The storage is a small on-chip register array of 36-bit words split into four 9-bit byte lanes.

Top module: `zt_sram_core`

## Requirements
- R1: After reset, `rdata_oe` is 0 and `rdata` is 0. No burst is active, so an advance cycle before the first load performs no access.
- R2: A read loaded at enabled edge k puts the word on `rdata` with `rdata_oe` = 1 after enabled edge k+2.
- R3: A write loaded at enabled edge k takes `wdata` at enabled edge k+2. Lane i (bits 9i+8..9i) is updated only when `lane_wr_n[i]` = 0 in the cycle of the command.
- R4: Reads and writes may follow each other in any order on consecutive cycles, one per clock, with no stall.
- R5: A read issued while an earlier write to the same address is still waiting for its data returns the value that write leaves in its enabled lanes.
- R6: The device is selected only when `en1_n` = 0, `en2` = 1 and `en3_n` = 0. A load cycle that is not selected performs no access, leaves memory unchanged and ends any burst.
- R7: `rdata_oe` is 0 in the data phase of a write and of a deselect cycle.
- R8: While `clk_en` = 0, all state is frozen: the pipeline, the burst counter, `rdata` and `rdata_oe`, and the array.
- R9: With `adv_ld` = 1 during an active burst, the low two address bits step from the loaded base as (base + n) mod 4 in linear order (`burst_lin` = 1). The upper bits stay unchanged.
- R10: In interleaved order (`burst_lin` = 0), the low two address bits are base XOR n, for n = 1, 2, 3, 0, ...
- R11: An advance cycle keeps the read or write type of the load that started the burst. On advance cycles, `wr_n` and the chip enables are ignored, but `lane_wr_n` is sampled.
- R12: The burst order is fixed by `burst_lin` at the load cycle. Its value on advance cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock qualifier; 0 freezes the core |
| addr | input | ADDR_W | Word address for load cycles |
| en1_n | input | 1 | Chip enable, active low |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles) |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new address |
| burst_lin | input | 1 | 1 = linear, 0 = interleaved order (load cycles) |
| wdata | input | LANES*LANE_W | Write data, taken two enabled edges after the command |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
A wrong address in the write pipeline stays hidden until that word is read back. A bench that fills the array and keeps reading it exposes the fault at the data phase of the next read, two edges after that read is issued. A missing or wrong coherency merge shows up in the first read issued right after a write to the same address. A broken burst counter shows up on the first advance cycle of a burst, as wrong data two edges later. Enable and freeze faults show at `rdata_oe` and `rdata` on the very next enabled edge, so the reference model compares both ports on every clock.

// File: rtl/zt_pkg.sv
package zt_pkg;
    // Burst ordering selected at load time
    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_ord_e;

    localparam int unsigned DEF_ADDR_W = 6;
    localparam int unsigned DEF_LANES  = 4;
    localparam int unsigned DEF_LANE_W = 9;
    localparam int unsigned BURST_W    = 2;
endpackage

// File: rtl/zt_burst_step.sv
module zt_burst_step
    import zt_pkg::*;
(
    input  logic [BURST_W-1:0] base_lo,
    input  logic [BURST_W-1:0] step,
    input  burst_ord_e         ord,
    output logic [BURST_W-1:0] addr_lo
);
    always_comb begin
        if (ord == ORD_LINEAR) addr_lo = base_lo + step;
        else                   addr_lo = base_lo ^ step;
    end
endmodule

// File: rtl/zt_lane_merge.sv
module zt_lane_merge #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    old_word,
    input  logic [DW-1:0]    new_word,
    input  logic [LANES-1:0] take_new,
    output logic [DW-1:0]    merged
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = take_new[l] ? new_word[l*LANE_W +: LANE_W]
                                                        : old_word[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/zt_reg_array.sv
module zt_reg_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DW    = LANES * LANE_W,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  wlanes,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we && wlanes[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
    import zt_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned LANE_W = DEF_LANE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      en1_n,
    input  logic                      en2,
    input  logic                      en3_n,
    input  logic                      wr_n,
    input  logic [LANES-1:0]          lane_wr_n,
    input  logic                      adv_ld,
    input  logic                      burst_lin,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic                      rdata_oe
);
    localparam int unsigned DW = LANES * LANE_W;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
    } cmd_t;

    typedef struct packed {
        cmd_t                s1;      // command one edge old
        cmd_t                s2;      // command two edges old (data phase now)
        logic                b_act;
        logic                b_wr;
        burst_ord_e          b_ord;
        logic [ADDR_W-1:0]   b_base;
        logic [BURST_W-1:0]  b_cnt;
        logic [DW-1:0]       rbuf;    // array word read one edge before output
        logic [DW-1:0]       dout;
        logic                oe;
    } state_t;

    state_t st_d, st_q;

    logic               selected;
    logic [BURST_W-1:0] cnt_inc;
    logic [BURST_W-1:0] adv_lo;
    logic [DW-1:0]      arr_word;
    logic [DW-1:0]      fwd_word;
    logic [LANES-1:0]   fwd_lanes;
    logic               arr_we;

    assign selected = ~en1_n & en2 & ~en3_n;
    assign cnt_inc  = st_q.b_cnt + BURST_W'(1);

    zt_burst_step u_step (
        .base_lo (st_q.b_base[BURST_W-1:0]),
        .step    (cnt_inc),
        .ord     (st_q.b_ord),
        .addr_lo (adv_lo)
    );

    // write data arrives for the command in stage 2
    assign arr_we = clk_en & st_q.s2.vld & st_q.s2.wr;

    zt_reg_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .we     (arr_we),
        .wlanes (st_q.s2.lanes),
        .waddr  (st_q.s2.addr),
        .wdata  (wdata),
        .raddr  (st_q.s1.addr),
        .rdata  (arr_word)
    );

    // coherency: an in-flight write to the read address overrides its lanes
    assign fwd_lanes = (st_q.s2.vld && st_q.s2.wr && (st_q.s2.addr == st_q.s1.addr))
                       ? st_q.s2.lanes : '0;

    zt_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .old_word (arr_word),
        .new_word (wdata),
        .take_new (fwd_lanes),
        .merged   (fwd_word)
    );

    always_comb begin
        cmd_t cmd;
        st_d = st_q;
        cmd  = '0;

        if (!adv_ld) begin
            if (selected) begin
                cmd.vld      = 1'b1;
                cmd.wr       = ~wr_n;
                cmd.addr     = addr;
                cmd.lanes    = ~lane_wr_n;
                st_d.b_act   = 1'b1;
                st_d.b_wr    = ~wr_n;
                st_d.b_ord   = burst_ord_e'(burst_lin);
                st_d.b_base  = addr;
                st_d.b_cnt   = '0;
            end else begin
                st_d.b_act   = 1'b0;
            end
        end else if (st_q.b_act) begin
            cmd.vld    = 1'b1;
            cmd.wr     = st_q.b_wr;
            cmd.addr   = {st_q.b_base[ADDR_W-1:BURST_W], adv_lo};
            cmd.lanes  = ~lane_wr_n;
            st_d.b_cnt = cnt_inc;
        end

        st_d.s1 = cmd;
        st_d.s2 = st_q.s1;

        if (st_q.s1.vld && !st_q.s1.wr) st_d.rbuf = fwd_word;
        if (st_q.s2.vld && !st_q.s2.wr) st_d.dout = st_q.rbuf;
        st_d.oe = st_q.s2.vld & ~st_q.s2.wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st_q <= '0;
        else if (clk_en) st_q <= st_d;
    end

    assign rdata    = st_q.dout;
    assign rdata_oe = st_q.oe;
endmodule

// File: rtl/zt_sram_core_chk.sv
module zt_sram_core_chk #(
    parameter int unsigned DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          adv_ld,
    input logic          wr_n,
    input logic          en1_n,
    input logic          en2,
    input logic          en3_n,
    input logic [DW-1:0] rdata,
    input logic          rdata_oe
);
    logic sel;
    logic rd1_q, rd2_q, wr1_q, wr2_q, ds1_q, ds2_q;

    assign sel = ~en1_n & en2 & ~en3_n;

    // track load commands over enabled edges; advance cycles are left untracked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd1_q <= 1'b0; rd2_q <= 1'b0;
            wr1_q <= 1'b0; wr2_q <= 1'b0;
            ds1_q <= 1'b0; ds2_q <= 1'b0;
        end else if (clk_en) begin
            rd1_q <= ~adv_ld & sel & wr_n;
            wr1_q <= ~adv_ld & sel & ~wr_n;
            ds1_q <= ~adv_ld & ~sel;
            rd2_q <= rd1_q;
            wr2_q <= wr1_q;
            ds2_q <= ds1_q;
        end
    end

    // R2
    read_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && rd2_q) |=> rdata_oe);

    // R7
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && wr2_q) |=> !rdata_oe);

    // R6
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && ds2_q) |=> !rdata_oe);

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(rdata) && $stable(rdata_oe)));
endmodule

bind zt_sram_core zt_sram_core_chk #(.DW(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .adv_ld   (adv_ld),
    .wr_n     (wr_n),
    .en1_n    (en1_n),
    .en2      (en2),
    .en3_n    (en3_n),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
);

// File: tb/zt_sram_core_test.sv
module zt_sram_core_test;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          en1_n = 1'b1, en2 = 1'b1, en3_n = 1'b0;
    logic          wr_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '1;
    logic          adv_ld = 1'b0;
    logic          burst_lin = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    always #4 clk = ~clk;

    zt_sram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr),
        .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .adv_ld(adv_ld), .burst_lin(burst_lin),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int    n_run = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    typedef struct { bit vld; bit wr; int a; bit [NL-1:0] ln; } mcmd_t;
    logic [DW-1:0] m_mem [DEPTH];
    mcmd_t         m_q[$];
    mcmd_t         m_new, m_old;
    bit            m_bact, m_bwr, m_blin;
    int            m_base, m_n, m_lo;
    logic [DW-1:0] e_rdata = '0;
    bit            e_oe = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_bact  = 1'b0;
            e_oe    = 1'b0;
            e_rdata = '0;
        end else if (clk_en) begin
            e_oe = 1'b0;
            if (m_q.size() == 2) begin
                m_old = m_q.pop_front();
                if (m_old.vld && !m_old.wr) begin
                    e_oe    = 1'b1;
                    e_rdata = m_mem[m_old.a];
                end
                if (m_old.vld && m_old.wr)
                    for (int l = 0; l < NL; l++)
                        if (m_old.ln[l]) m_mem[m_old.a][l*LW +: LW] = wdata[l*LW +: LW];
            end
            m_new = '{vld: 1'b0, wr: 1'b0, a: 0, ln: '0};
            if (!adv_ld) begin
                if (!en1_n && en2 && !en3_n) begin
                    m_new  = '{vld: 1'b1, wr: !wr_n, a: int'(addr), ln: ~lane_wr_n};
                    m_bact = 1'b1; m_bwr = !wr_n; m_blin = burst_lin;
                    m_base = int'(addr); m_n = 0;
                end else m_bact = 1'b0;
            end else if (m_bact) begin
                m_n  = (m_n + 1) % 4;
                m_lo = m_blin ? ((m_base % 4) + m_n) % 4 : ((m_base % 4) ^ m_n);
                m_new = '{vld: 1'b1, wr: m_bwr, a: (m_base / 4) * 4 + m_lo, ln: ~lane_wr_n};
            end
            m_q.push_back(m_new);
        end
    end

    task automatic check_outputs();
        n_run++;
        if (rdata_oe !== e_oe) begin
            n_fail++;
            $display("FAIL %s rdata_oe actual %b expected %b", cur_req, rdata_oe, e_oe);
        end
        if (e_oe) begin
            n_run++;
            if (rdata !== e_rdata) begin
                n_fail++;
                $display("FAIL %s rdata actual %h expected %h", cur_req, rdata, e_rdata);
            end
        end
    endtask

    // cs: 0 selected, 1 en1_n high, 2 en2 low, 3 en3_n high
    task automatic step(bit ce, bit adv, bit wr, bit [NL-1:0] lnn, int a, bit lin, int cs);
        @(negedge clk);
        check_outputs();
        clk_en    = ce;
        adv_ld    = adv;
        wr_n      = !wr;
        lane_wr_n = lnn;
        addr      = AW'(a);
        burst_lin = lin;
        en1_n     = (cs == 1);
        en2       = (cs != 2);
        en3_n     = (cs == 3);
        wdata     = {4'($urandom), 32'($urandom)};
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, '1, 0, 1'b1, 1);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired during %s", cur_req);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        n_run++;
        if (rdata_oe !== 1'b0 || rdata !== '0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual oe=%b data=%h expected oe=0 data=0", rdata_oe, rdata);
        end
        cur_req = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, '1, 5, 1'b1, 0);
        idle(3);

        cur_req = "R3";   // fill every word, all lanes
        for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, 1'b1, '0, a, 1'b1, 0);
        cur_req = "R2";
        for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, 1'b0, '1, a, 1'b1, 0);
        idle(3);

        cur_req = "R3";   // partial lane writes then readback
        for (int i = 0; i < 64; i++) step(1'b1, 1'b0, 1'b1, NL'($urandom), $urandom % DEPTH, 1'b1, 0);
        for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, 1'b0, '1, a, 1'b1, 0);
        idle(3);

        cur_req = "R4";   // mixed back-to-back traffic
        for (int i = 0; i < 1500; i++)
            step(1'b1, 1'b0, 1'($urandom), NL'($urandom), $urandom % DEPTH, 1'b1, 0);
        idle(3);

        cur_req = "R5";   // read right after write to the same word
        for (int i = 0; i < 40; i++) begin
            int a;
            a = $urandom % DEPTH;
            step(1'b1, 1'b0, 1'b1, NL'($urandom), a, 1'b1, 0);
            step(1'b1, 1'b0, 1'b0, '1, a, 1'b1, 0);
            step(1'b1, 1'b0, 1'b0, '1, a, 1'b1, 0);
            if (i % 4 == 0) idle(1);
        end
        idle(3);

        cur_req = "R6";   // deselected writes must not reach the array
        for (int i = 0; i < 30; i++) begin
            int a;
            a = $urandom % DEPTH;
            step(1'b1, 1'b0, 1'b1, '0, a, 1'b1, 1 + (i % 3));
            step(1'b1, 1'b0, 1'b0, '1, a, 1'b1, 0);
        end
        idle(3);

        cur_req = "R7";   // alternating write / read data phases
        for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 1'(i % 2), '0, $urandom % DEPTH, 1'b1, 0);
        idle(3);

        cur_req = "R8";   // clock enable stalls at random
        for (int i = 0; i < 800; i++)
            step(1'($urandom % 3 != 0), 1'($urandom % 4 == 0), 1'($urandom), NL'($urandom),
                 $urandom % DEPTH, 1'($urandom), $urandom % 5 == 0 ? 1 : 0);
        idle(4);

        cur_req = "R9";   // linear bursts, write then read
        for (int i = 0; i < 12; i++) begin
            int b;
            b = $urandom % DEPTH;
            step(1'b1, 1'b0, 1'b1, '0, b, 1'b1, 0);
            for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0, '0, 0, 1'b1, 0);
            step(1'b1, 1'b0, 1'b0, '1, b, 1'b1, 0);
            for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0, '1, 0, 1'b1, 0);
        end
        idle(3);

        cur_req = "R10";  // interleaved bursts
        for (int i = 0; i < 12; i++) begin
            int b;
            b = $urandom % DEPTH;
            step(1'b1, 1'b0, 1'b1, '0, b, 1'b0, 0);
            for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, '0, 0, 1'b0, 0);
            step(1'b1, 1'b0, 1'b0, '1, b, 1'b0, 0);
            for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0, '1, 0, 1'b0, 0);
        end
        idle(3);

        cur_req = "R11";  // type kept, wr_n and enables ignored on advance
        for (int i = 0; i < 12; i++) begin
            int b;
            b = $urandom % DEPTH;
            step(1'b1, 1'b0, 1'b1, '0, b, 1'b1, 0);
            for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0, NL'($urandom), 0, 1'b1, 1 + k);
            step(1'b1, 1'b0, 1'b0, '1, b, 1'b1, 0);
            for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, '1, 0, 1'b1, 1 + k);
            step(1'b1, 1'b0, 1'b0, '1, b, 1'b1, 2);   // deselect ends burst
            step(1'b1, 1'b1, 1'b1, '0, 0, 1'b1, 0);
            step(1'b1, 1'b1, 1'b0, '1, 0, 1'b1, 0);
        end
        idle(3);

        cur_req = "R12";  // order input toggled on advance cycles
        for (int i = 0; i < 12; i++) begin
            int b;
            bit o;
            b = $urandom % DEPTH;
            o = 1'(i % 2);
            step(1'b1, 1'b0, 1'b1, '0, b, o, 0);
            for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, '0, 0, 1'(k), 0);
            step(1'b1, 1'b0, 1'b0, '1, b, o, 0);
            for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0, '1, 0, !o, 0);
        end
        idle(4);

        finish_run();
    end
endmodule